// File: doc/BRIEF.md
# Dual-lane serial converter readout controller

This block runs one conversion-and-readout cycle of a two-channel successive-approximation converter. The converter has a conversion-start line and one serial data line per channel. On a start request the controller drives the conversion-start line low, which begins a conversion. It then waits for a programmable conversion time. After that it issues a burst of 16 serial clocks. Each clock phase has a programmable length in system clock cycles.

The converter changes its data lines on each falling serial clock. The controller samples both lines on rising edges. It can use its own serial clock for this or the echo clock that the converter returns. Both the data lines and the echo line pass through a synchronizer, and both capture paths have the same latency. The first 15 bits of a frame are the result, most significant bit first. The 16th bit is a constant zero and is discarded. Each 15-bit two's-complement result is sign-extended to 16 bits. Both lanes are presented together with a one-cycle valid pulse, and the conversion-start line returns high in that same cycle.

Top module: `adc_readout_ctrl`

## Requirements
- R1: While reset is held and after it is released, `cnv` is 1, `sck` is 0, `busy` is 0, `sample_valid` is 0 and `sample_data` is all zero.
- R2: A `start` pulse sampled while `busy` is 0 makes `cnv` 0 and `busy` 1 from the next cycle.
- R3: The first rising edge of `sck` in a frame comes exactly `conv_cycles`+2 system clock cycles after the falling edge of `cnv`.
- R4: Each frame has exactly 16 rising edges of `sck`. Every high phase lasts max(`half_div`,1) cycles, and so does every low phase between two rising edges. `sck` is 0 whenever `busy` is 0.
- R5: With `use_echo`=0, each data line is sampled once for each rising edge of `sck`. The first 15 samples form the result, most significant bit first, and the 16th sample is discarded.
- R6: With `use_echo`=1, each data line is sampled once for each rising edge of `echo_in` during the frame, with the same bit ordering as R5.
- R7: Lane k occupies `sample_data[16k+15:16k]`. It holds the 15-bit two's-complement result with bit 15 equal to bit 14. Full scale positive (0x3FFF) gives 0x3FFF, and full scale negative (0x4000 as 15 bits) gives 0xC000.
- R8: `sample_valid` is high for exactly one cycle per frame. Both lanes update in that cycle and `cnv` returns to 1 in it. `sample_data` changes only when `sample_valid` is high.
- R9: A `start` that arrives while `busy` is 1 has no effect. `cnv` stays 0 until the frame's valid pulse, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion and readout |
| use_echo | input | 1 | 1: capture on the echo clock; 0: capture on the controller's own serial clock |
| half_div | input | DIV_W | System clock cycles per serial clock phase (0 treated as 1) |
| conv_cycles | input | CONV_W | Conversion wait count |
| cnv | output | 1 | Conversion-start line; falling edge starts a conversion |
| sck | output | 1 | Serial clock to the converter |
| echo_in | input | 1 | Echo clock returned by the converter |
| sdo_in | input | LANES | Serial data line of each lane |
| sample_data | output | LANES*16 | Sign-extended results, lane 0 in the low bits |
| sample_valid | output | 1 | One-cycle pulse when new results are present |
| busy | output | 1 | High from an accepted start until the valid pulse |

## Verification
Several internal faults show up at the ports within one frame. A wrong conversion counter moves the first serial clock away from the expected cycle. A miscounted phase or edge counter changes the pulse widths or the number of rising edges. A misaligned capture strobe or a swapped shift direction corrupts the sample presented at the next valid pulse. Sweeps of walking-one and arithmetic codes, run in both capture modes, make a single stuck or shifted bit visible in the first frame where that bit differs. A sequencer fault that keeps the frame running or restarts it appears as `cnv` staying low, or as a second burst of clocks in the idle cycles after the valid pulse.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    // Frame format fixed by the converter: sign + 14 magnitude bits + one zero
    localparam int FRAME_CLKS = 16;
    localparam int RES_BITS   = 15;
    localparam int SAMPLE_W   = 16;
    localparam int FCNT_W     = $clog2(FRAME_CLKS + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_SHIFT,
        ST_DRAIN
    } rd_state_t;

    // Drop the trailing zero and sign-extend the result to the sample width
    function automatic logic [SAMPLE_W-1:0] frame_to_sample(input logic [FRAME_CLKS-1:0] f);
        logic [RES_BITS-1:0] r;
        r = f[FRAME_CLKS-1 -: RES_BITS];
        return {{(SAMPLE_W-RES_BITS){r[RES_BITS-1]}}, r};
    endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/adc_rd_sckgen.sv
module adc_rd_sckgen
    import adc_rd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             sck,
    output logic             rise_stb,
    output logic             done
);
    localparam logic [FCNT_W-1:0] LAST_FALL = FCNT_W'(FRAME_CLKS - 1);

    logic [DIV_W-1:0]  hc_q;
    logic [FCNT_W-1:0] falls_q;
    logic              fin_q;
    logic [DIV_W-1:0]  hd_eff;
    logic              tog;

    assign hd_eff = (half_div == '0) ? DIV_W'(1) : half_div;
    assign tog    = run && !fin_q && (hc_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sck      <= 1'b0;
            hc_q     <= '0;
            falls_q  <= '0;
            fin_q    <= 1'b0;
            rise_stb <= 1'b0;
            done     <= 1'b0;
        end else begin
            rise_stb <= tog && !sck;
            done     <= 1'b0;
            if (tog) begin
                sck  <= ~sck;
                hc_q <= hd_eff - 1'b1;
                if (sck) begin
                    falls_q <= falls_q + 1'b1;
                    if (falls_q == LAST_FALL) begin
                        fin_q <= 1'b1;
                        done  <= 1'b1;
                    end
                end
            end else if (hc_q != '0) begin
                hc_q <= hc_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_rd_lane.sv
module adc_rd_lane
    import adc_rd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  shift_en,
    input  logic                  din,
    output logic [FRAME_CLKS-1:0] frame
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            frame <= '0;
        end else if (shift_en) begin
            frame <= {frame[FRAME_CLKS-2:0], din};
        end
    end
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
    import adc_rd_pkg::*;
#(
    parameter int LANES       = 2,
    parameter int DIV_W       = 8,
    parameter int CONV_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      use_echo,
    input  logic [DIV_W-1:0]          half_div,
    input  logic [CONV_W-1:0]         conv_cycles,
    output logic                      cnv,
    output logic                      sck,
    input  logic                      echo_in,
    input  logic [LANES-1:0]          sdo_in,
    output logic [LANES*SAMPLE_W-1:0] sample_data,
    output logic                      sample_valid,
    output logic                      busy
);
    localparam logic [FCNT_W-1:0] FRAME_N = FCNT_W'(FRAME_CLKS);

    rd_state_t         state_q;
    logic [CONV_W-1:0] conv_cnt_q;
    logic [FCNT_W-1:0] cap_cnt_q;
    logic              sck_run;
    logic              sck_rise;
    logic              sck_done;
    logic [LANES:0]    synced;
    logic              echo_s;
    logic [LANES-1:0]  sdo_s;
    logic              echo_d_q;
    logic [SYNC_STAGES-1:0] rise_pipe_q;
    logic              cap_window;
    logic              cap_en;
    logic              lane_clear;
    logic              accept;
    logic              frame_end;
    logic [FRAME_CLKS-1:0] lane_frame [LANES];

    assign busy       = (state_q != ST_IDLE);
    assign accept     = (state_q == ST_IDLE) && start;
    assign lane_clear = accept;
    assign sck_run    = (state_q == ST_SHIFT);
    assign frame_end  = (state_q == ST_DRAIN) && (cap_cnt_q == FRAME_N);

    // Serial clock generation
    adc_rd_sckgen #(.DIV_W(DIV_W)) u_sckgen (
        .clk      (clk),
        .rst      (rst),
        .run      (sck_run),
        .half_div (half_div),
        .sck      (sck),
        .rise_stb (sck_rise),
        .done     (sck_done)
    );

    // Echo and data lines share one synchronizer so both capture paths align
    adc_rd_sync #(.W(LANES + 1), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({echo_in, sdo_in}),
        .dout (synced)
    );
    assign echo_s = synced[LANES];
    assign sdo_s  = synced[LANES-1:0];

    // Own-clock strobe delayed by the synchronizer depth; echo edge detect
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_pipe_q <= '0;
            echo_d_q    <= 1'b0;
        end else begin
            rise_pipe_q[0] <= sck_rise;
            for (int i = 1; i < SYNC_STAGES; i++) rise_pipe_q[i] <= rise_pipe_q[i-1];
            echo_d_q <= echo_s;
        end
    end

    assign cap_window = ((state_q == ST_SHIFT) || (state_q == ST_DRAIN)) && (cap_cnt_q < FRAME_N);
    assign cap_en     = cap_window && (use_echo ? (echo_s && !echo_d_q)
                                                : rise_pipe_q[SYNC_STAGES-1]);

    // Per-lane shift registers
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        adc_rd_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .clear    (lane_clear),
            .shift_en (cap_en),
            .din      (sdo_s[g]),
            .frame    (lane_frame[g])
        );
    end

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            conv_cnt_q   <= '0;
            cap_cnt_q    <= '0;
            cnv          <= 1'b1;
            sample_valid <= 1'b0;
            sample_data  <= '0;
        end else begin
            sample_valid <= 1'b0;
            if (cap_en) cap_cnt_q <= cap_cnt_q + 1'b1;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q    <= ST_CONV;
                        cnv        <= 1'b0;
                        conv_cnt_q <= '0;
                        cap_cnt_q  <= '0;
                    end
                end
                ST_CONV: begin
                    if (conv_cnt_q == conv_cycles) state_q <= ST_SHIFT;
                    else                           conv_cnt_q <= conv_cnt_q + 1'b1;
                end
                ST_SHIFT: begin
                    if (sck_done) state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (frame_end) begin
                        state_q      <= ST_IDLE;
                        cnv          <= 1'b1;
                        sample_valid <= 1'b1;
                        for (int i = 0; i < LANES; i++)
                            sample_data[i*SAMPLE_W +: SAMPLE_W] <= frame_to_sample(lane_frame[i]);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker
    import adc_rd_pkg::*;
#(
    parameter int LANES = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      start,
    input logic                      cnv,
    input logic                      sck,
    input logic                      busy,
    input logic                      sample_valid,
    input logic [LANES*SAMPLE_W-1:0] sample_data
);
    // R2: accepted start lowers the conversion line next cycle
    a_r2_start_lowers_cnv: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (!cnv && busy));

    // R9: conversion line stays low for the whole frame
    a_r9_cnv_low_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cnv);

    // R4: no serial clock outside a frame
    a_r4_sck_within_frame: assert property (@(posedge clk) disable iff (rst)
        sck |-> busy);

    // R3: serial clock is low when a conversion begins
    a_r3_sck_low_at_start: assert property (@(posedge clk) disable iff (rst)
        $fell(cnv) |-> !sck);

    // R8: valid is a single-cycle pulse
    a_r8_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    // R8: samples change only with the valid pulse
    a_r8_data_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(sample_data) |-> sample_valid);

    // R7: every presented lane is sign-extended
    for (genvar k = 0; k < LANES; k++) begin : g_sext
        a_r7_sign_extended: assert property (@(posedge clk) disable iff (rst)
            sample_valid |-> (sample_data[k*SAMPLE_W + SAMPLE_W-1] == sample_data[k*SAMPLE_W + RES_BITS-1]));
    end
endmodule

bind adc_readout_ctrl adc_rd_checker #(.LANES(LANES)) u_chk (.*);

// File: tb/adc_readout_ctrl_test.sv
`timescale 1ns/1ps
module adc_readout_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        use_echo = 1'b0;
    logic [7:0]  half_div = 8'd1;
    logic [9:0]  conv_cycles = 10'd0;
    wire         cnv;
    wire         sck;
    logic        echo_r = 1'b0;
    wire  [1:0]  sdo_w;
    wire  [31:0] sample_data;
    wire         sample_valid;
    wire         busy;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    adc_readout_ctrl uut (
        .clk(clk), .rst(rst), .start(start), .use_echo(use_echo),
        .half_div(half_div), .conv_cycles(conv_cycles),
        .cnv(cnv), .sck(sck), .echo_in(echo_r), .sdo_in(sdo_w),
        .sample_data(sample_data), .sample_valid(sample_valid), .busy(busy)
    );

    // Converter model: result latched at the conversion-start edge, data
    // advances 3 ns after each falling serial clock, echo follows by 3 ns.
    logic [14:0] code0, code1, m_lat0, m_lat1;
    int          m_idx = 0;
    logic        m_oe = 1'b0;

    function automatic logic m_bit(input logic [14:0] c, input int i);
        return (i < 15) ? c[14-i] : 1'b0;
    endfunction

    always @(negedge cnv) begin
        m_lat0 = code0;
        m_lat1 = code1;
        m_idx  = 0;
        m_oe   = 1'b1;
    end
    always @(negedge sck) begin
        #3;
        if (m_oe) begin
            m_idx = m_idx + 1;
            if (m_idx >= 16) m_oe = 1'b0;
        end
    end
    always @(posedge sck) begin #3; echo_r = 1'b1; end
    always @(negedge sck) begin #3; echo_r = 1'b0; end

    assign sdo_w[0] = m_oe ? m_bit(m_lat0, m_idx) : 1'bz;
    assign sdo_w[1] = m_oe ? m_bit(m_lat1, m_idx) : 1'bz;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [14:0] c0, input logic [14:0] c1,
                             input int hd, input int cv, input bit echo, input bit poke);
        int t, rises, first_rise, run_len, hd_eff, bad_w;
        bit got, prev;
        logic [31:0] snap, expd;
        hd_eff = (hd == 0) ? 1 : hd;
        code0 = c0; code1 = c1;
        half_div = 8'(hd); conv_cycles = 10'(cv); use_echo = echo;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(!cnv && busy, "R2", "cnv low/busy after start", {30'd0, cnv, busy}, 32'd1);
        t = 0; rises = 0; first_rise = -1; run_len = 0; bad_w = 0; got = 0; prev = 1'b0;
        snap = '0;
        while (!got && t < 4000) begin
            @(negedge clk);
            t++;
            start = (poke && (t == 3)) ? 1'b1 : 1'b0;
            if (sck && !prev) begin
                rises++;
                if (first_rise < 0) first_rise = t;
                if (rises > 1 && run_len != hd_eff) bad_w++;
                run_len = 1;
            end else if (!sck && prev) begin
                if (run_len != hd_eff) bad_w++;
                run_len = 1;
            end else begin
                run_len++;
            end
            prev = sck;
            if (sample_valid) begin
                got = 1;
                snap = sample_data;
                check(cnv == 1'b1, "R8", "cnv high with valid", {31'd0, cnv}, 32'd1);
            end
        end
        start = 1'b0;
        check(got, "R8", "valid pulse seen", {31'd0, got}, 32'd1);
        check(first_rise == cv + 2, "R3", "first sck rise delay", first_rise, cv + 2);
        check(rises == 16, "R4", "sck rising edges", rises, 16);
        check(bad_w == 0, "R4", "sck phase widths", bad_w, 0);
        expd = {c1[14], c1, c0[14], c0};
        check(snap == expd, echo ? "R6" : "R5", "captured lanes", snap, expd);
        if (c0 == 15'h3FFF || c0 == 15'h4000)
            check(snap[15:0] == expd[15:0], "R7", "full-scale lane 0", snap[15:0], expd[15:0]);
        @(negedge clk);
        check(!sample_valid, "R8", "valid single cycle", {31'd0, sample_valid}, 32'd0);
        for (int i = 0; i < 10; i++) begin
            if (i > 0) @(negedge clk);
            if (sample_data != snap || !cnv || sck || busy) begin
                check(0, poke ? "R9" : "R8", "idle hold after frame",
                      {sample_data[29:0], cnv, sck}, {snap[29:0], 2'b10});
                break;
            end
        end
        tests++;
    endtask

    task automatic sweep(input int hd, input int cv, input bit echo);
        run_frame(15'h3FFF, 15'h4000, hd, cv, echo, 1'b0);
        run_frame(15'h4000, 15'h3FFF, hd, cv, echo, 1'b0);
        run_frame(15'h0000, 15'h7FFF, hd, cv, echo, 1'b1);
        for (int b = 0; b < 15; b++)
            run_frame(15'(1 << b), ~15'(1 << b), hd, cv, echo, 1'b0);
        for (int i = 0; i < 6; i++)
            run_frame(15'((i * 4093 + 17) % 32768), 15'((i * 7919 + 3) % 32768), hd, cv, echo, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        code0 = '0; code1 = '0; m_lat0 = '0; m_lat1 = '0;
        repeat (3) @(negedge clk);
        check(cnv && !sck && !busy && !sample_valid && sample_data == 32'd0, "R1", "state in reset",
              {28'd0, cnv, sck, busy, sample_valid}, 32'h8);
        rst = 1'b0;
        @(negedge clk);
        check(cnv && !sck && !busy && !sample_valid && sample_data == 32'd0, "R1", "state after reset",
              {28'd0, cnv, sck, busy, sample_valid}, 32'h8);

        sweep(1, 0, 1'b0);
        sweep(3, 5, 1'b0);
        sweep(0, 2, 1'b0);
        sweep(2, 1, 1'b1);
        sweep(4, 7, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule